// File: doc/BRIEF.md
# Hold-Preferring Stage State Selector

This block chooses the next switching state of one stage of a cascaded multilevel inverter, once per sampling interval. The reference voltage arrives in a 60-degree two-axis (g/h) frame as two signed integers. The block keeps its own previous state internally. On each sample strobe it decides whether the reference can still be reached from the previous state's vector, once the lower stages add their contribution. If it can, the state is kept. If it cannot, the block moves to a reachable state that needs the fewest phase-leg changes. The reference minus the vector of the chosen state is handed down as the residual reference for the next stage.

Parameters configure the stage. LEVELS is 2 for a two-level stage and 3 for a three-level stage. VDC is the stage's step voltage, and RADIUS is the half-width of the hexagon that all lower stages together can cover. Both are given in input LSBs. With half-Vs LSBs, the defaults set up the high stage: LEVELS=2, VDC=18 (9 Vs) and RADIUS=17 (8.5 Vs). A medium stage would use LEVELS=3, VDC=6 (3 Vs) and RADIUS=5 (2.5 Vs). Keeping the higher stages in their present state as long as possible keeps their switching rate low.

Top module: `stage_sel`

## Requirements
- R1: The state holds one field per phase, each in 0..LEVELS-1. The fields are packed as state_o = {a, b, c} with phase a in the most significant field. Each field is 1 bit wide for LEVELS=2 and 2 bits wide otherwise.
- R2: The vector of state (a,b,c) is g = VDC*(a-b) and h = VDC*(b-c), in input LSBs.
- R3: A state's domain contains the reference when, with (dg, dh) = reference minus the state's vector, all of |dg|, |dh| and |dg+dh| are at most RADIUS. If the domain of the previous state contains the reference, the previous state is kept.
- R4: Otherwise, among the states whose domain contains the reference, the one with the smallest transition distance is chosen. Transition distance is the sum over phases of |new-old|. Ties go to the lowest index a*LEVELS^2 + b*LEVELS + c.
- R5: When no domain contains the reference, the state with the smallest hexagonal distance max(|dg|,|dh|,|dg+dh|) is chosen. Ties go to the lowest index.
- R6: The residual outputs equal the sampled reference minus the vector of the chosen state. They are registered together with the state.
- R7: State and residual change only on a clock edge where sample_i is high. Otherwise they hold, whatever the reference does.
- R8: Reset sets the state to all zeros and both residuals to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sampling-interval strobe |
| ref_g_i | input | W | Reference g component, signed |
| ref_h_i | input | W | Reference h component, signed |
| state_o | output | 3*SW | Chosen state {a,b,c} |
| res_g_o | output | W+1 | Residual g component for the stage below, signed |
| res_h_o | output | W+1 | Residual h component for the stage below, signed |

## Verification
The assertions check four things on every strobe and every idle cycle. When the previous domain contains the reference, the state is kept. The residual always matches the registered state and the sampled reference. The residual stays inside the domain whenever any domain contained the reference. The outputs freeze without a strobe. Only the directed scenarios can show which state wins: a move to the candidate with fewest leg changes rather than the lowest index, the lowest-index rule between equally near candidates, and the nearest-hexagon fallback with its tie rule.

// File: rtl/sel_pkg.sv
package sel_pkg;

    function automatic int abs_i(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int max3_i(input int x, input int y, input int z);
        int m;
        m = (x > y) ? x : y;
        return (m > z) ? m : z;
    endfunction

    // hexagonal norm of an offset in the 60-degree frame
    function automatic int hex_norm(input int dg, input int dh);
        return max3_i(abs_i(dg), abs_i(dh), abs_i(dg + dh));
    endfunction

    function automatic int vec_g(input int vdc, input int a, input int b);
        return vdc * (a - b);
    endfunction

    function automatic int vec_h(input int vdc, input int b, input int c);
        return vdc * (b - c);
    endfunction

endpackage

// File: rtl/stage_cand.sv
module stage_cand
    import sel_pkg::*;
#(
    parameter int LEVELS = 2,
    parameter int W      = 10,
    parameter int VDC    = 18,
    parameter int RADIUS = 17,
    parameter int IDX    = 0,
    parameter int SW     = 1,
    parameter int DW     = 13
) (
    input  logic signed [W-1:0]    ref_g,
    input  logic signed [W-1:0]    ref_h,
    input  logic        [3*SW-1:0] prev,
    output logic                   inside_o,
    output logic        [DW-1:0]   hex_o,
    output logic        [3:0]      trans_o
);
    localparam int CA = IDX / (LEVELS * LEVELS);
    localparam int CB = (IDX / LEVELS) % LEVELS;
    localparam int CC = IDX % LEVELS;

    int dg, dh, pa, pb, pc;

    always_comb begin
        dg = int'(ref_g) - vec_g(VDC, CA, CB);
        dh = int'(ref_h) - vec_h(VDC, CB, CC);
        inside_o = (abs_i(dg) <= RADIUS) && (abs_i(dh) <= RADIUS)
                   && (abs_i(dg + dh) <= RADIUS);
        hex_o = DW'(hex_norm(dg, dh));
        pa = int'(prev[3*SW-1 -: SW]);
        pb = int'(prev[2*SW-1 -: SW]);
        pc = int'(prev[SW-1:0]);
        trans_o = 4'(abs_i(CA - pa) + abs_i(CB - pb) + abs_i(CC - pc));
    end

endmodule

// File: rtl/stage_sel.sv
module stage_sel
    import sel_pkg::*;
#(
    parameter int LEVELS = 2,
    parameter int W      = 10,
    parameter int VDC    = 18,
    parameter int RADIUS = 17,
    localparam int SW    = (LEVELS > 2) ? 2 : 1,
    localparam int RW    = W + 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  sample_i,
    input  logic signed [W-1:0]   ref_g_i,
    input  logic signed [W-1:0]   ref_h_i,
    output logic [3*SW-1:0]       state_o,
    output logic signed [RW-1:0]  res_g_o,
    output logic signed [RW-1:0]  res_h_o
);
    localparam int NC = LEVELS * LEVELS * LEVELS;
    localparam int DW = W + 3;
    localparam int KW = DW + 1;

    typedef struct packed {
        logic [3*SW-1:0]      state;
        logic signed [RW-1:0] rg;
        logic signed [RW-1:0] rh;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NC-1:0]  inside_w;
    logic [DW-1:0]  hex_w   [NC];
    logic [3:0]     trans_w [NC];

    for (genvar i = 0; i < NC; i++) begin : g_cand
        stage_cand #(
            .LEVELS(LEVELS), .W(W), .VDC(VDC), .RADIUS(RADIUS),
            .IDX(i), .SW(SW), .DW(DW)
        ) u_cand (
            .ref_g   (ref_g_i),
            .ref_h   (ref_h_i),
            .prev    (regs_q.state),
            .inside_o(inside_w[i]),
            .hex_o   (hex_w[i]),
            .trans_o (trans_w[i])
        );
    end

    logic [KW-1:0] key, best_key;
    int best_idx, na, nb, nc;

    // Inside candidates rank by leg changes (the previous state scores 0),
    // outside ones by hexagonal distance; strict compare keeps lowest index.
    always_comb begin
        best_key = inside_w[0] ? {1'b0, DW'(trans_w[0])} : {1'b1, hex_w[0]};
        best_idx = 0;
        for (int i = 1; i < NC; i++) begin
            key = inside_w[i] ? {1'b0, DW'(trans_w[i])} : {1'b1, hex_w[i]};
            if (key < best_key) begin
                best_key = key;
                best_idx = i;
            end
        end
        na = best_idx / (LEVELS * LEVELS);
        nb = (best_idx / LEVELS) % LEVELS;
        nc = best_idx % LEVELS;

        regs_d = regs_q;
        if (sample_i) begin
            regs_d.state = {SW'(na), SW'(nb), SW'(nc)};
            regs_d.rg    = RW'(int'(ref_g_i) - vec_g(VDC, na, nb));
            regs_d.rh    = RW'(int'(ref_h_i) - vec_h(VDC, nb, nc));
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign state_o = regs_q.state;
    assign res_g_o = regs_q.rg;
    assign res_h_o = regs_q.rh;

    // ---------------- assertions ----------------
    logic [SW-1:0] fa, fb, fc;
    logic          prev_in;
    assign fa = state_o[3*SW-1 -: SW];
    assign fb = state_o[2*SW-1 -: SW];
    assign fc = state_o[SW-1:0];
    assign prev_in = inside_w[int'(fa) * LEVELS * LEVELS + int'(fb) * LEVELS + int'(fc)];

    p_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(fa) < LEVELS) && (int'(fb) < LEVELS) && (int'(fc) < LEVELS));

    p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_i && prev_in) |=> (state_o == $past(state_o)));

    p_domain_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_i && (|inside_w)) |=>
            (abs_i(int'(res_g_o)) <= RADIUS) && (abs_i(int'(res_h_o)) <= RADIUS)
            && (abs_i(int'(res_g_o) + int'(res_h_o)) <= RADIUS));

    p_resid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_i |=>
            (int'(res_g_o) == int'($past(ref_g_i)) - VDC * (int'(fa) - int'(fb)))
            && (int'(res_h_o) == int'($past(ref_h_i)) - VDC * (int'(fb) - int'(fc))));

    p_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sample_i |=> ($stable(state_o) && $stable(res_g_o) && $stable(res_h_o)));

endmodule

// File: tb/tb_stage_sel.sv
`timescale 1ns/1ps
module tb_stage_sel;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sample = 1'b0;
    logic signed [9:0] rg = '0, rh = '0;
    logic [2:0]        st;
    logic signed [10:0] og, oh;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stage_sel dut (
        .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
        .ref_g_i(rg), .ref_h_i(rh),
        .state_o(st), .res_g_o(og), .res_h_o(oh)
    );

    task automatic check(input string req, input logic [2:0] es, input int eg, input int eh);
        n_chk++;
        if (st !== es || int'(og) != eg || int'(oh) != eh) begin
            n_bad++;
            $display("FAIL %s: state=%b res=(%0d,%0d) expected state=%b res=(%0d,%0d)",
                     req, st, og, oh, es, eg, eh);
        end
    endtask

    // drive at negedge, strobe across one posedge, sample at next negedge
    task automatic step(input int g, input int h);
        @(negedge clk);
        rg = 10'(g); rh = 10'(h); sample = 1'b1;
        @(negedge clk);
        sample = 1'b0;
    endtask

    task automatic t_reset;   // R8
        check("R8 reset", 3'b000, 0, 0);
    endtask

    task automatic t_hold;    // R3, R2 via residual
        step(5, 3);   check("R3 hold at zero", 3'b000, 5, 3);
        step(20, 0);  check("R4 single move", 3'b100, 2, 0);
        step(10, 0);  check("R3 hold in overlap", 3'b100, -8, 0);
        step(0, 20);  check("R2 move and residual", 3'b110, 0, 2);
    endtask

    task automatic t_fewest;  // R4: 111 has 1 leg change, beats 000 and 101
        step(10, -10); check("R4 fewest transitions", 3'b111, 10, -10);
    endtask

    task automatic t_nearest; // R5
        step(60, 0);  check("R5 nearest outside", 3'b100, 42, 0);
        step(5, -5);  check("R4 tie lowest index", 3'b000, 5, -5);
        step(30, -60); check("R5 tie lowest index", 3'b001, 30, -42);
    endtask

    task automatic t_no_strobe; // R7
        @(negedge clk); rg = 10'sd100; rh = -10'sd100;
        repeat (3) @(negedge clk);
        check("R7 no strobe", 3'b001, 30, -42);
        rg = 10'sd0; rh = 10'sd0;
        @(negedge clk);
        check("R7 no strobe again", 3'b001, 30, -42);
    endtask

    task automatic t_range;   // R1, R6: 001 -> (0,0): 000 one change
        step(0, 0);   check("R6 residual after move", 3'b000, 0, 0);
        step(-20, 20); check("R1 field order a-high", 3'b010, -2, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_fewest();
        t_nearest();
        t_no_strobe();
        t_range();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule